// File: doc/BRIEF.md
# Framed 8-bit PCM Serial Port with Load Strobe

This block moves 8-bit PCM samples between a serial codec link and the parallel datapath of a voice-processing engine. There are two channels: a send path and a receive path. Each has one serial input lane and one serial output lane. The external bit clock and frame sync are oversampled by the fast master clock. The block detects the bit clock edges in the master clock domain, so it works with any bit clock from 64 kHz to 2048 kHz, provided the master clock is at least eight times faster.

On the input side, both lanes are shifted in MSB first. The block samples on the falling edge of the bit clock, beginning at the first falling edge that finds the frame sync high. Once the eighth bit is in, the pair of bytes is offered on a valid/ready stream, and a load strobe stays high for one bit-clock period. The load strobe is meant to start the per-frame processing.

The receive stream holds its data until it is accepted. It does not stall the serial link: if a new pair completes before the old one is taken, the new pair replaces the old one and valid stays high.

On the output side, a valid/ready stream accepts one pair of bytes into a single-entry holding register. Ready is high exactly when that register is empty. At each frame start the held pair moves into the shifters and the holding register empties. If nothing is held at frame start, the idle code is sent. Each output lane has an enable that marks its 8-bit slot; outside the slot the pad is to be left undriven. A power-down input clears all state and keeps both enables low.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, load_strobe, rx_valid, snd_out_en and rcv_out_en are 0 and tx_ready is 1.
- R2: Input bits are sampled on bit clock falling edges, MSB first. The MSB is the bit sampled on the first falling edge at which the frame sync is high after a falling edge at which it was low. The following seven falling edges supply the remaining bits, whether the sync is still high or not.
- R3: load_strobe rises after the falling edge that samples the eighth bit and falls at the next falling edge, so it lasts one bit clock period.
- R4: rx_valid rises together with load_strobe and stays high, with its words stable, until a cycle in which rx_ready is high. A pair completed while rx_valid is still high replaces the held words.
- R5: Output bits change only on bit clock rising edges and go out MSB first. The MSB is driven from the first rising edge at which the frame sync is high after a rising edge at which it was low.
- R6: Each output enable rises on the frame-start rising edge and falls on the ninth rising edge, so it covers exactly eight bit periods.
- R7: The words sent in a frame are the ones held at frame start. A pair accepted during the frame does not change the byte in flight, and it goes out in the following frame.
- R8: If no pair is held at frame start, both lanes send the idle code 8'hFF.
- R9: While pwr_down is high, both output enables stay 0, load_strobe and rx_valid stay 0, and the holding register is emptied, so tx_ready is 1.
- R10: tx_ready is 0 from the cycle after a pair is accepted until the next frame start takes that pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down: clears state and idles the outputs |
| bclk | input | 1 | External serial bit clock |
| fsync | input | 1 | 8 kHz frame sync |
| snd_in | input | 1 | Send-path serial input |
| rcv_in | input | 1 | Receive-path serial input |
| load_strobe | output | 1 | High for one bit period after both input bytes are loaded |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Consumer takes the received pair |
| rx_snd | output | 8 | Received send-path byte |
| rx_rcv | output | 8 | Received receive-path byte |
| tx_valid | input | 1 | Producer offers a pair to transmit |
| tx_ready | output | 1 | Holding register empty |
| tx_snd | input | 8 | Send-path byte to transmit |
| tx_rcv | input | 8 | Receive-path byte to transmit |
| snd_out | output | 1 | Send-path serial output data |
| snd_out_en | output | 1 | Send-path output enable (low means high impedance) |
| rcv_out | output | 1 | Receive-path serial output data |
| rcv_out_en | output | 1 | Receive-path output enable (low means high impedance) |

## Verification
The bench sweeps all 256 transmit byte values. It alternates one-bit and two-bit frame sync pulses, so the design must not restart a word when the sync is still high on a second edge; a design that did would shift the received byte and lengthen the output window. The bench checks the enables and the load strobe in every bit period around the slot, which catches an off-by-one window or a strobe that lasts a master cycle instead of a bit period. It also checks:
- a pair pushed in the middle of a frame, which a design that does not latch at frame start would splice into the byte in flight;
- an empty holding register at frame start, which must send the idle code and not stale data;
- two frames completed with no consumer, where the second pair must win;
- a power-down frame, which must stay silent and leave the holding register empty.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned PCM_W = 8;
  typedef logic [PCM_W-1:0] pcm_word_t;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LANES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bclk,
  input  logic [LANES-1:0] lanes_in,
  output logic             bclk_rise,
  output logic             bclk_fall,
  output logic [LANES-1:0] lanes_lvl
);
  logic [STAGES-1:0] clk_pipe;
  logic              clk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      clk_last <= 1'b0;
    end else if (clr) begin
      clk_pipe <= '0;
      clk_last <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], bclk};
      clk_last <= clk_pipe[STAGES-1];
    end
  end

  assign bclk_rise = clk_pipe[STAGES-1] & ~clk_last;
  assign bclk_fall = ~clk_pipe[STAGES-1] & clk_last;

  // Data lanes get the same depth as the clock so they stay aligned with it.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pipe <= '0;
      else if (clr) pipe <= '0;
      else          pipe <= {pipe[STAGES-2:0], lanes_in[g]};
    end
    assign lanes_lvl[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
  import pcm_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      fall,
  input  logic      sync_lvl,
  input  logic      snd_bit,
  input  logic      rcv_bit,
  input  logic      rx_ready,
  output logic      strobe,
  output logic      rx_valid,
  output pcm_word_t rx_snd,
  output pcm_word_t rx_rcv
);
  localparam int unsigned CW = $clog2(PCM_W + 1);

  logic [CW-1:0] cnt;
  pcm_word_t     sh_s, sh_r;
  logic          sync_pf;

  logic start, mid, last;
  assign start = fall && sync_lvl && !sync_pf;
  assign mid   = fall && !start && (cnt != '0);
  assign last  = mid && (cnt == CW'(PCM_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sh_s <= '0; sh_r <= '0; sync_pf <= 1'b0;
      strobe <= 1'b0; rx_valid <= 1'b0; rx_snd <= '0; rx_rcv <= '0;
    end else if (clr) begin
      cnt <= '0; sh_s <= '0; sh_r <= '0; sync_pf <= 1'b0;
      strobe <= 1'b0; rx_valid <= 1'b0; rx_snd <= '0; rx_rcv <= '0;
    end else begin
      if (fall) begin
        sync_pf <= sync_lvl;
        strobe  <= 1'b0;
      end
      if (start) begin
        sh_s <= {sh_s[PCM_W-2:0], snd_bit};
        sh_r <= {sh_r[PCM_W-2:0], rcv_bit};
        cnt  <= CW'(1);
      end else if (mid) begin
        sh_s <= {sh_s[PCM_W-2:0], snd_bit};
        sh_r <= {sh_r[PCM_W-2:0], rcv_bit};
        cnt  <= last ? '0 : cnt + 1'b1;
      end
      if (last) begin
        rx_snd   <= {sh_s[PCM_W-2:0], snd_bit};
        rx_rcv   <= {sh_r[PCM_W-2:0], rcv_bit};
        strobe   <= 1'b1;
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(strobe) |-> $past(fall)); // R3
  AST_STROBE_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $fell(strobe) |-> $past(fall)); // R3
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (rx_valid && !rx_ready) |=> rx_valid); // R4
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
  import pcm_port_pkg::*;
#(
  parameter pcm_word_t IDLE_CODE = '1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      rise,
  input  logic      sync_lvl,
  input  logic      tx_valid,
  input  pcm_word_t tx_snd,
  input  pcm_word_t tx_rcv,
  output logic      tx_ready,
  output logic      snd_d,
  output logic      rcv_d,
  output logic      out_en
);
  localparam int unsigned CW = $clog2(PCM_W + 1);

  logic [CW-1:0] cnt;
  pcm_word_t     sh_s, sh_r, hold_s, hold_r;
  logic          hold_full, sync_pr;

  logic start, step, take, accept;
  assign start  = rise && sync_lvl && !sync_pr;
  assign step   = rise && !start && out_en;
  assign take   = start && hold_full;
  assign accept = tx_valid && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sh_s <= '0; sh_r <= '0; hold_s <= '0; hold_r <= '0;
      hold_full <= 1'b0; sync_pr <= 1'b0; out_en <= 1'b0;
    end else if (clr) begin
      cnt <= '0; sh_s <= '0; sh_r <= '0; hold_s <= '0; hold_r <= '0;
      hold_full <= 1'b0; sync_pr <= 1'b0; out_en <= 1'b0;
    end else begin
      if (rise) sync_pr <= sync_lvl;
      if (start) begin
        sh_s   <= hold_full ? hold_s : IDLE_CODE;
        sh_r   <= hold_full ? hold_r : IDLE_CODE;
        out_en <= 1'b1;
        cnt    <= CW'(1);
      end else if (step) begin
        if (cnt == CW'(PCM_W)) begin
          out_en <= 1'b0;
          cnt    <= '0;
        end else begin
          sh_s <= sh_s << 1;
          sh_r <= sh_r << 1;
          cnt  <= cnt + 1'b1;
        end
      end
      if (take) begin
        hold_full <= 1'b0;
      end else if (accept) begin
        hold_full <= 1'b1;
        hold_s    <= tx_snd;
        hold_r    <= tx_rcv;
      end
    end
  end

  assign tx_ready = !hold_full;
  assign snd_d    = sh_s[PCM_W-1];
  assign rcv_d    = sh_r[PCM_W-1];

  AST_OUT_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (out_en && $past(out_en) && !$past(rise)) |-> ($stable(snd_d) && $stable(rcv_d))); // R5
  AST_EN_OPENS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(out_en) |-> $past(rise)); // R6
  AST_EN_CLOSES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $fell(out_en) |-> $past(rise)); // R6
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ($past(hold_full) && hold_full) |-> ($stable(hold_s) && $stable(hold_r))); // R7
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  IDLE_CODE   = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             bclk,
  input  logic             fsync,
  input  logic             snd_in,
  input  logic             rcv_in,
  output logic             load_strobe,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [PCM_W-1:0] rx_snd,
  output logic [PCM_W-1:0] rx_rcv,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [PCM_W-1:0] tx_snd,
  input  logic [PCM_W-1:0] tx_rcv,
  output logic             snd_out,
  output logic             snd_out_en,
  output logic             rcv_out,
  output logic             rcv_out_en
);
  localparam int unsigned LANES = 3;

  logic             rise, fall;
  logic [LANES-1:0] lvl;
  logic             out_en;

  pcm_edge_sync #(.STAGES(SYNC_STAGES), .LANES(LANES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down), .bclk(bclk),
    .lanes_in({rcv_in, snd_in, fsync}),
    .bclk_rise(rise), .bclk_fall(fall), .lanes_lvl(lvl)
  );

  pcm_rx_deser u_rx (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down), .fall(fall),
    .sync_lvl(lvl[0]), .snd_bit(lvl[1]), .rcv_bit(lvl[2]),
    .rx_ready(rx_ready), .strobe(load_strobe), .rx_valid(rx_valid),
    .rx_snd(rx_snd), .rx_rcv(rx_rcv)
  );

  pcm_tx_ser #(.IDLE_CODE(pcm_word_t'(IDLE_CODE))) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down), .rise(rise),
    .sync_lvl(lvl[0]), .tx_valid(tx_valid), .tx_snd(tx_snd), .tx_rcv(tx_rcv),
    .tx_ready(tx_ready), .snd_d(snd_out), .rcv_d(rcv_out), .out_en(out_en)
  );

  assign snd_out_en = out_en;
  assign rcv_out_en = out_en;

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!snd_out_en && !rcv_out_en && !load_strobe && !rx_valid && tx_ready)); // R9
endmodule

// File: tb/sim_pcm_serial_port.sv
`timescale 1ns/1ps
module sim_pcm_serial_port;
  localparam int NPER = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_down = 1'b0, bclk = 1'b0, fsync = 1'b0;
  logic snd_in = 1'b0, rcv_in = 1'b0, rx_ready = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_snd = '0, tx_rcv = '0;
  logic load_strobe, rx_valid, tx_ready, snd_out, snd_out_en, rcv_out, rcv_out_en;
  logic [7:0] rx_snd, rx_rcv;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pcm_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bclk(bclk), .fsync(fsync),
    .snd_in(snd_in), .rcv_in(rcv_in), .load_strobe(load_strobe),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_snd(rx_snd), .rx_rcv(rx_rcv),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_snd(tx_snd), .tx_rcv(tx_rcv),
    .snd_out(snd_out), .snd_out_en(snd_out_en), .rcv_out(rcv_out), .rcv_out_en(rcv_out_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R10: a pushed pair fills the holding register
  task automatic push(input logic [7:0] s, input logic [7:0] r);
    @(negedge clk);
    tx_valid = 1'b1; tx_snd = s; tx_rcv = r;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R10 tx_ready low after accept", tx_ready, 0);
  endtask

  // R2 R4: read the received pair and hand it off
  task automatic pop(input logic [7:0] es, input logic [7:0] er);
    @(negedge clk);
    chk("R4 rx_valid", rx_valid, 1);
    chk("R2 rx_snd", rx_snd, es);
    chk("R2 rx_rcv", rx_rcv, er);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk("R4 rx_valid cleared", rx_valid, 0);
  endtask

  task automatic run_frame(input logic [7:0] sb, input logic [7:0] rb, input int sync_len,
                           input bit active, input logic [7:0] es, input logic [7:0] er,
                           input int push_at, input logic [7:0] ps, input logic [7:0] pr);
    for (int i = 0; i < NPER; i++) begin
      @(negedge clk);
      bclk = 1'b1;
      fsync = (i < sync_len);
      snd_in = (i < 8) ? sb[7-i] : 1'b0;
      rcv_in = (i < 8) ? rb[7-i] : 1'b0;
      if (i == push_at) begin
        tx_valid = 1'b1; tx_snd = ps; tx_rcv = pr;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (7) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      if (active) begin
        chk("R6 snd window", snd_out_en, (i < 8));
        chk("R6 rcv window", rcv_out_en, (i < 8));
        if (i < 8) begin
          chk("R5 R7 R8 snd bit", snd_out, es[7-i]);
          chk("R5 R7 R8 rcv bit", rcv_out, er[7-i]);
        end
        chk("R3 strobe", load_strobe, (i == 8));
      end else begin
        chk("R9 snd quiet", snd_out_en, 0);
        chk("R9 rcv quiet", rcv_out_en, 0);
        chk("R9 strobe quiet", load_strobe, 0);
      end
      bclk = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    // R1: state under and after reset
    chk("R1 strobe", load_strobe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 snd_en", snd_out_en, 0);
    chk("R1 rcv_en", rcv_out_en, 0);
    chk("R1 tx_ready", tx_ready, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8: nothing held at frame start, so the idle code goes out
    run_frame(8'hA5, 8'h3C, 1, 1'b1, 8'hFF, 8'hFF, -1, 8'h00, 8'h00);
    pop(8'hA5, 8'h3C);

    // Sweep all transmit bytes, alternating sync widths (R2 R5 R6 R10)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] sb;
      sb = 8'(v * 7 + 1);
      push(8'(v), 8'(v) ^ 8'hC3);
      run_frame(sb, ~8'(v), (v % 2 == 1) ? 2 : 1, 1'b1, 8'(v), 8'(v) ^ 8'hC3, -1, 8'h00, 8'h00);
      chk("R10 tx_ready after take", tx_ready, 1);
      pop(sb, ~8'(v));
    end

    // R7: push during a frame; byte in flight stays, new pair goes next
    push(8'h11, 8'h22);
    run_frame(8'h0F, 8'hF0, 1, 1'b1, 8'h11, 8'h22, 3, 8'h99, 8'h66);
    chk("R10 R7 new pair pending", tx_ready, 0);
    // R4: second pair completes before the first is taken and replaces it
    run_frame(8'h5A, 8'hC6, 2, 1'b1, 8'h99, 8'h66, -1, 8'h00, 8'h00);
    pop(8'h5A, 8'hC6);

    // R9: power-down silences everything and empties the holding register
    push(8'h44, 8'h55);
    @(negedge clk);
    pwr_down = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 tx_ready", tx_ready, 1);
    run_frame(8'h81, 8'h7E, 1, 1'b0, 8'h00, 8'h00, -1, 8'h00, 8'h00);
    chk("R9 rx_valid", rx_valid, 0);
    pwr_down = 1'b0;
    repeat (5) @(negedge clk);
    run_frame(8'h81, 8'h7E, 1, 1'b1, 8'hFF, 8'hFF, -1, 8'h00, 8'h00);
    pop(8'h81, 8'h7E);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule